// File: doc/BRIEF.md
# Eight-bit timer with compare match

The block is an 8-bit up-counter driven by a selectable tick source. It has a compare register, two sticky event flags and an interrupt mask, and all of them are reached through a small synchronous register bus. A 3-bit clock-select field picks the tick source. The counter can be stopped, advanced on every system clock, advanced on a tap of a free-running prescaler (divide by 8, 64, 256 or 1024), or advanced on rising or falling edges of an external pin. The external pin is synchronized and edge-detected in the system clock domain.

On each tick the counter is compared with the compare register. A tick taken while the two are equal sets the compare flag. A tick taken at 255 wraps the counter to 0 and sets the overflow flag. When software writes the counter, the compare check on the next tick is skipped. This stops a freshly loaded value from raising a spurious match. Each flag drives an interrupt request when both its mask bit and the global enable input are set.

Top module: `tmr8_cmp`

## Requirements
- R1: After reset the counter, compare, control, mask and flag registers all read 0, and both interrupt requests are low.
- R2: With clock-select code 000 the counter holds its value.
- R3: Clock-select codes 001, 010, 011, 100 and 101 advance the counter once every 1, 8, 64, 256 and 1024 system clocks.
- R4: Code 111 advances the counter once per rising edge of `ext_clk` and code 110 once per falling edge, each after a two-flop synchronizer.
- R5: A write to address 0 loads the counter, and the new value reads back on the next cycle. A bus write to the counter takes priority over a tick in the same cycle.
- R6: A tick taken while the counter equals the compare register (address 1) sets the compare flag, which is flag register bit 1.
- R7: The first tick after a counter write never sets the compare flag, even when the counter equals the compare value.
- R8: A tick taken at 255 wraps the counter to 0 and sets the overflow flag, which is flag register bit 0.
- R9: Writing the flag register (address 4) clears each flag whose written bit is 1 and leaves unchanged each flag whose written bit is 0.
- R10: `irq_cmp` is high exactly when flag bit 1, mask bit 1 (address 3) and `gie` are all set. `irq_ovf` is high exactly when flag bit 0, mask bit 0 and `gie` are all set.
- R11: Address 2 holds the clock select in bits 2:0 and address 3 holds the mask in bits 1:0. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| ext_clk | input | 1 | External count pin (asynchronous) |
| gie | input | 1 | Global interrupt enable |
| irq_cmp | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
A table of the five internal clock-select codes is walked, and the number of system clocks between successive counter steps is measured for each one. This tells the tap choices apart and would catch an off-by-one tap. The compare path is checked twice with the counter passing through the compare value: once after a counter write well ahead of the match, where the flag must set, and once with the counter loaded directly onto the compare value, where the first tick must not set it. External pulses are applied under both edge codes so that a swapped polarity or a double count shows up. Counter wrap, flag clearing with mixed bit patterns, and the interrupt gating by mask and `gie` are checked as directed cases.

// File: rtl/tmr8_cmp.sv
module tmr8_cmp #(
  parameter int CW  = 8,
  parameter int PSW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic          ext_clk,
  input  logic          gie,
  output logic          irq_cmp,
  output logic          irq_ovf
);
  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0]  cnt, cmpv;
  logic [2:0]     csel;
  logic [1:0]     mask, flags;
  logic [PSW-1:0] psc;
  logic [2:0]     xs;
  logic           blk, tick;

  wire wr_cnt = wr_en && addr == 3'd0;
  wire rise   = xs[1] & ~xs[2];
  wire fall   = ~xs[1] & xs[2];
  wire hit    = tick && !blk && !wr_cnt && cnt == cmpv;
  wire wrap   = tick && !wr_cnt && cnt == TOP;

  always_comb begin
    case (csel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &psc[2:0];
      3'd3:    tick = &psc[5:0];
      3'd4:    tick = &psc[7:0];
      3'd5:    tick = &psc[9:0];
      3'd6:    tick = fall;
      3'd7:    tick = rise;
      default: tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc <= '0;
      xs  <= '0;
    end else begin
      psc <= psc + 1'b1;
      xs  <= {xs[1:0], ext_clk};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      blk <= 1'b0;
    end else if (wr_cnt) begin
      cnt <= wdata;
      blk <= 1'b1;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
      blk <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpv  <= '0;
      csel  <= '0;
      mask  <= '0;
      flags <= '0;
    end else begin
      if (wr_en && addr == 3'd1) cmpv <= wdata;
      if (wr_en && addr == 3'd2) csel <= wdata[2:0];
      if (wr_en && addr == 3'd3) mask <= wdata[1:0];
      flags <= (flags & ~((wr_en && addr == 3'd4) ? wdata[1:0] : 2'b00)) | {hit, wrap};
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0: rdata = cnt;
      3'd1: rdata = cmpv;
      3'd2: rdata[2:0] = csel;
      3'd3: rdata[1:0] = mask;
      3'd4: rdata[1:0] = flags;
      default: rdata = '0;
    endcase
  end

  assign irq_cmp = gie & mask[1] & flags[1];
  assign irq_ovf = gie & mask[0] & flags[0];
endmodule

// File: rtl/tmr8_cmp_chk.sv
module tmr8_cmp_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [CW-1:0] wdata,
  input logic          gie,
  input logic          irq_cmp,
  input logic          irq_ovf,
  input logic [CW-1:0] cnt,
  input logic [2:0]    csel,
  input logic [1:0]    flags,
  input logic          tick,
  input logic          blk
);
  wire wc = wr_en && addr == 3'd0;

  a_r5_cnt_load: assert property (@(posedge clk) disable iff (!rst_n)
    wc |=> cnt == $past(wdata));

  a_r2_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (csel == 3'd0 && !wc) |=> $stable(cnt));

  a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && blk && !wc && !flags[1]) |=> !flags[1]);

  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wc && cnt == '1) |=> (cnt == '0 && flags[0]));

  a_r10_gie_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (!irq_cmp && !irq_ovf));
endmodule

bind tmr8_cmp tmr8_cmp_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .gie(gie), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf), .cnt(cnt),
  .csel(csel), .flags(flags), .tick(tick), .blk(blk)
);

// File: tb/sim_tmr8_cmp.sv
module sim_tmr8_cmp;
  logic clk = 0, rst_n = 0, wr_en = 0, ext_clk = 0, gie = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq_cmp, irq_ovf;
  int checks = 0, errors = 0;

  localparam int NV = 5;
  localparam logic [2:0] CODES [NV] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
  localparam int PERIODS [NV] = '{1, 8, 64, 256, 1024};

  tmr8_cmp u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
               .rdata(rdata), .ext_clk(ext_clk), .gie(gie), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic peek(input logic [2:0] a, output int v);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, prev, per;
    repeat (3) step();
    rst_n = 1;
    step();
    for (int a = 0; a < 8; a++) begin
      peek(3'(a), v);
      chk($sformatf("R1/R11 reset read addr %0d", a), v, 0);
    end
    chk("R1 irq_cmp reset", int'(irq_cmp), 0);
    chk("R1 irq_ovf reset", int'(irq_ovf), 0);

    wr(3'd2, 8'h0D);
    peek(3'd2, v); chk("R11 control holds 3 bits", v, 5);
    wr(3'd3, 8'hFE);
    peek(3'd3, v); chk("R11 mask holds 2 bits", v, 2);

    for (int i = 0; i < NV; i++) begin
      wr(3'd2, {5'd0, CODES[i]});
      peek(3'd0, prev);
      for (int k = 0; k < 1100; k++) begin step(); peek(3'd0, v); if (v != prev) break; end
      prev = v; per = 0;
      for (int k = 0; k < 1100; k++) begin step(); per++; peek(3'd0, v); if (v != prev) break; end
      chk($sformatf("R3 tick period code %0d", CODES[i]), per, PERIODS[i]);
    end

    wr(3'd2, 0);
    peek(3'd0, prev);
    repeat (50) step();
    peek(3'd0, v); chk("R2 stopped counter holds", v, prev);
    wr(3'd0, 8'hA5);
    peek(3'd0, v); chk("R5 counter load", v, 165);

    gie = 1;
    wr(3'd1, 5); wr(3'd0, 3); wr(3'd4, 3); wr(3'd2, 1);
    peek(3'd0, v); chk("R6 start value", v, 3);
    step(); step();
    peek(3'd4, v); chk("R6 no flag before match", v, 0);
    step();
    peek(3'd0, v); chk("R6 counter after match tick", v, 6);
    peek(3'd4, v); chk("R6 compare flag set", v, 2);
    chk("R10 irq_cmp with mask and gie", int'(irq_cmp), 1);
    chk("R10 irq_ovf with flag clear", int'(irq_ovf), 0);
    gie = 0; #1;
    chk("R10 irq_cmp gated by gie", int'(irq_cmp), 0);
    gie = 1;
    wr(3'd2, 0);
    wr(3'd4, 0);
    peek(3'd4, v); chk("R9 writing 0 leaves flag", v, 2);
    wr(3'd4, 2);
    peek(3'd4, v); chk("R9 writing 1 clears flag", v, 0);

    wr(3'd1, 7); wr(3'd0, 7); wr(3'd2, 1);
    peek(3'd0, v); chk("R7 loaded on compare value", v, 7);
    step();
    peek(3'd0, v); chk("R7 counter advanced", v, 8);
    peek(3'd4, v); chk("R7 match blocked after write", v, 0);

    wr(3'd2, 0); wr(3'd1, 100); wr(3'd3, 1); wr(3'd0, 254); wr(3'd2, 1);
    peek(3'd0, v); chk("R8 start 254", v, 254);
    step();
    peek(3'd0, v); chk("R8 reaches 255", v, 255);
    peek(3'd4, v); chk("R8 no flag at 255", v, 0);
    step();
    peek(3'd0, v); chk("R8 wraps to 0", v, 0);
    peek(3'd4, v); chk("R8 overflow flag", v, 1);
    chk("R10 irq_ovf asserted", int'(irq_ovf), 1);
    chk("R10 irq_cmp masked", int'(irq_cmp), 0);
    wr(3'd4, 1);
    peek(3'd4, v); chk("R9 overflow flag cleared", v, 0);

    wr(3'd2, 0); wr(3'd0, 0); wr(3'd4, 3); wr(3'd2, 7);
    for (int p = 0; p < 3; p++) begin
      ext_clk = 1; repeat (5) step();
      ext_clk = 0; repeat (5) step();
    end
    peek(3'd0, v); chk("R4 rising edges counted", v, 3);
    wr(3'd2, 6);
    ext_clk = 1; repeat (5) step();
    peek(3'd0, v); chk("R4 rising edge ignored on falling code", v, 3);
    ext_clk = 0; repeat (5) step();
    for (int p = 0; p < 2; p++) begin
      ext_clk = 1; repeat (5) step();
      ext_clk = 0; repeat (5) step();
    end
    peek(3'd0, v); chk("R4 falling edges counted", v, 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule